// File: doc/BRIEF.md
# Nested Priority Interrupt Controller

This block sits next to a small processor core and merges a set of interrupt request lines into one interrupt signal. Every line has a fixed priority: the line with the larger index wins. A rising edge on a request line is captured as a pending request. The request stays pending until the core acknowledges it, so a pulse of one cycle is not lost. The core answers `int_o` with `ack_i`. At that moment the controller moves the line it is offering into its in-service set and shows that line on `svc_id_o`. The core later signals the end of the handler with `eos_i`.

A run-time mode input selects one of two service policies. In queue mode (`nest_mode_i` = 0) there is never more than one interrupt in service. Requests that arrive during service raise nothing and simply wait. After the end of service they are offered one at a time, oldest first. In nesting mode (`nest_mode_i` = 1) a pending request whose priority is strictly above every line in service raises `int_o` and pre-empts the running handler. The in-service set is a bitmask, and each end of service retires its highest bit. This returns the controller to the interrupted lower-priority level.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After a synchronous active-low reset, `int_o` = 0, `active_o` = 0, `svc_id_o` = 0, and no request is pending.
- R2: A rising edge on `irq_i[k]` that is sampled at a clock edge makes line k pending from that edge on, and the line stays pending until it is acknowledged. A level that is still high after its acknowledgement does not make the line pending again.
- R3: Priority grows with the line index. In nesting mode with nothing in service, acknowledging several pending lines takes the highest index first.
- R4: In queue mode, `int_o` stays 0 while any line is in service, and requests that arrive in that time stay pending.
- R5: In queue mode, pending lines are served in the order in which they became pending. Lines whose edges are sampled at the same clock edge are served higher index first.
- R6: In nesting mode, a pending line with an index above the highest in-service line raises `int_o`. Its acknowledgement makes `svc_id_o` show that line.
- R7: In nesting mode, a pending line with an index equal to or below the highest in-service line never raises `int_o`.
- R8: `eos_i` removes the highest in-service line, and `svc_id_o` returns to the next lower in-service line. `active_o` falls when the set becomes empty.
- R9: When `ack_i` (while `int_o` = 1) and `eos_i` occur in the same cycle, the highest in-service line is removed and the offered line is added, both in that one cycle.
- R10: `ack_i` has no effect while `int_o` = 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| nest_mode_i | input | 1 | 0 = queue mode, 1 = nesting mode |
| irq_i | input | N_LINES | Request lines, captured on a rising edge; a higher index means a higher priority |
| ack_i | input | 1 | Core accepts the offered interrupt |
| eos_i | input | 1 | Core finished the highest in-service handler |
| int_o | output | 1 | Interrupt to the core |
| active_o | output | 1 | At least one line is in service |
| svc_id_o | output | $clog2(N_LINES) | Index of the highest in-service line |

## Verification
Two functions can fall in the same cycle: the end of service of the running handler and the acknowledgement of a pre-empting interrupt. The bench provokes this in nesting mode. It puts line 3 in service and makes line 6 pending, then raises `ack_i` and `eos_i` together for one cycle. The result must show line 6 in service. A single further end of service must then leave the set empty, which shows that line 3 was retired in the same cycle and not kept underneath.

// File: rtl/pic_pkg.sv
`timescale 1ns/1ps
// pic_pkg: shared types and helpers of the priority interrupt controller.
// Assumes no more than 32 request lines.
package pic_pkg;
    typedef enum logic {
        MODE_QUEUE = 1'b0,
        MODE_NEST  = 1'b1
    } pic_mode_e;

    localparam int unsigned PIC_MAX_LINES = 32;
endpackage

// File: rtl/pic_capture.sv
`timescale 1ns/1ps
// pic_capture: turns request-line edges into pending bits and records
// their relative age. Assumes irq_i is synchronous to clk.
// older_q[i][j] = 1 means that line i became pending before line j.
module pic_capture #(
    parameter int unsigned N_LINES = 8,
    localparam int unsigned IDW = $clog2(N_LINES)
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic [N_LINES-1:0]              irq_i,
    input  logic                            take_i,
    input  logic [IDW-1:0]                  take_id_i,
    output logic [N_LINES-1:0]              pending_o,
    output logic [N_LINES-1:0][N_LINES-1:0] older_o
);
    logic [N_LINES-1:0] req_q, pend_q, kept, fresh;
    logic [N_LINES-1:0][N_LINES-1:0] older_q;

    // keep the pending bits that are not being taken; mark newly pending lines
    always_comb begin
        for (int i = 0; i < N_LINES; i++) begin
            kept[i]  = pend_q[i] & ~(take_i && (take_id_i == IDW'(i)));
            fresh[i] = irq_i[i] & ~req_q[i] & ~kept[i];
        end
    end

    // register the request history and the pending set
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            req_q  <= '0;
            pend_q <= '0;
        end else begin
            req_q  <= irq_i;
            pend_q <= kept | fresh;
        end
    end

    // update age entries for each pair that involves a newly pending line
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            older_q <= '0;
        end else begin
            for (int i = 0; i < N_LINES; i++) begin
                for (int j = 0; j < N_LINES; j++) begin
                    if (i != j && (fresh[i] || fresh[j])) begin
                        older_q[i][j] <= (fresh[i] && fresh[j]) ? (i > j) : fresh[j];
                    end
                end
            end
        end
    end

    assign pending_o = pend_q;
    assign older_o   = older_q;

    // R2
    pend_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fresh != '0) |=> ((pending_o & $past(fresh)) == $past(fresh)));
endmodule

// File: rtl/pic_select.sv
`timescale 1ns/1ps
// pic_select: chooses the line to offer to the core. Queue mode offers the
// oldest pending line and only when nothing is in service. Nesting mode
// offers the highest pending line above the highest in-service line.
// This module is purely combinational.
module pic_select #(
    parameter int unsigned N_LINES = 8,
    localparam int unsigned IDW = $clog2(N_LINES)
) (
    input  pic_pkg::pic_mode_e              mode_i,
    input  logic [N_LINES-1:0]              pending_i,
    input  logic [N_LINES-1:0][N_LINES-1:0] older_i,
    input  logic [N_LINES-1:0]              isr_mask_i,
    input  logic [IDW-1:0]                  isr_top_i,
    output logic                            offer_o,
    output logic [IDW-1:0]                  offer_id_o
);
    logic [N_LINES-1:0] eligible;
    logic [N_LINES-1:0] oldest;

    // find the lines that may be offered under the current mode
    always_comb begin
        for (int j = 0; j < N_LINES; j++) begin
            if (mode_i == pic_pkg::MODE_NEST) begin
                eligible[j] = pending_i[j] && ((isr_mask_i == '0) || (j > int'(isr_top_i)));
            end else begin
                eligible[j] = pending_i[j] && (isr_mask_i == '0);
            end
        end
    end

    // mark eligible lines that no other pending line is older than
    always_comb begin
        for (int i = 0; i < N_LINES; i++) begin
            oldest[i] = eligible[i];
            for (int j = 0; j < N_LINES; j++) begin
                if (j != i && pending_i[j] && older_i[j][i]) begin
                    oldest[i] = 1'b0;
                end
            end
        end
    end

    // pick the winner: highest eligible line when nesting, oldest line in queue mode
    always_comb begin
        offer_id_o = '0;
        for (int i = 0; i < N_LINES; i++) begin
            if (mode_i == pic_pkg::MODE_NEST ? eligible[i] : oldest[i]) begin
                offer_id_o = IDW'(i);
            end
        end
    end

    assign offer_o = |eligible;
endmodule

// File: rtl/pic_isr_stack.sv
`timescale 1ns/1ps
// pic_isr_stack: holds the in-service lines as a bitmask. An accepted
// acknowledgement sets the offered bit, and an end of service clears the
// highest set bit. When both occur in one cycle, the clear acts on the old top.
module pic_isr_stack #(
    parameter int unsigned N_LINES = 8,
    localparam int unsigned IDW = $clog2(N_LINES)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               take_i,
    input  logic [IDW-1:0]     take_id_i,
    input  logic               eos_i,
    output logic [N_LINES-1:0] mask_o,
    output logic [IDW-1:0]     top_o
);
    logic [N_LINES-1:0] mask_q, mask_d;
    logic [IDW-1:0]     top;

    // locate the highest in-service line
    always_comb begin
        top = '0;
        for (int i = 0; i < N_LINES; i++) begin
            if (mask_q[i]) top = IDW'(i);
        end
    end

    // retire the top line on end of service, then add the taken line
    always_comb begin
        mask_d = mask_q;
        if (eos_i && mask_q != '0) mask_d[top] = 1'b0;
        if (take_i) mask_d[take_id_i] = 1'b1;
    end

    // register the in-service mask
    always_ff @(posedge clk) begin
        if (!rst_n) mask_q <= '0;
        else        mask_q <= mask_d;
    end

    assign mask_o = mask_q;
    assign top_o  = top;

    // R8
    eos_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (eos_i && !take_i && mask_q != '0) |=> ($countones(mask_q) == $countones($past(mask_q)) - 1));
    // R10
    mask_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!take_i && !eos_i) |=> $stable(mask_q));
endmodule

// File: rtl/prio_irq_ctrl.sv
`timescale 1ns/1ps
// prio_irq_ctrl: a priority interrupt controller with a run-time choice of
// queue mode and nesting mode. A higher line index means a higher priority.
// Assumes irq_i is synchronous to clk and N_LINES <= 32.
module prio_irq_ctrl #(
    parameter int unsigned N_LINES = 8,
    localparam int unsigned IDW = $clog2(N_LINES)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               nest_mode_i,
    input  logic [N_LINES-1:0] irq_i,
    input  logic               ack_i,
    input  logic               eos_i,
    output logic               int_o,
    output logic               active_o,
    output logic [IDW-1:0]     svc_id_o
);
    pic_pkg::pic_mode_e              mode;
    logic [N_LINES-1:0]              pending, isr_mask;
    logic [N_LINES-1:0][N_LINES-1:0] older;
    logic [IDW-1:0]                  sel_id, isr_top;
    logic                            offer, take;

    assign mode = pic_pkg::pic_mode_e'(nest_mode_i);
    assign take = ack_i && offer;

    pic_capture #(.N_LINES(N_LINES)) u_capture (
        .clk(clk), .rst_n(rst_n), .irq_i(irq_i), .take_i(take),
        .take_id_i(sel_id), .pending_o(pending), .older_o(older)
    );

    pic_select #(.N_LINES(N_LINES)) u_select (
        .mode_i(mode), .pending_i(pending), .older_i(older),
        .isr_mask_i(isr_mask), .isr_top_i(isr_top),
        .offer_o(offer), .offer_id_o(sel_id)
    );

    pic_isr_stack #(.N_LINES(N_LINES)) u_stack (
        .clk(clk), .rst_n(rst_n), .take_i(take), .take_id_i(sel_id),
        .eos_i(eos_i), .mask_o(isr_mask), .top_o(isr_top)
    );

    assign int_o    = offer;
    assign active_o = |isr_mask;
    assign svc_id_o = isr_top;

    // R4
    queue_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == pic_pkg::MODE_QUEUE && active_o) |-> !int_o);
    // R6
    take_id_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (take && !eos_i) |=> (svc_id_o >= $past(sel_id)));
    // R7
    nest_above_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == pic_pkg::MODE_NEST && active_o && int_o) |-> (sel_id > svc_id_o));
    // R2
    int_needs_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
        int_o |-> (pending != '0));
endmodule

// File: tb/test_prio_irq_ctrl.sv
`timescale 1ns/1ps
// test_prio_irq_ctrl: directed scenarios, one task each, for prio_irq_ctrl.
module test_prio_irq_ctrl;
    localparam int unsigned N = 8;
    localparam int unsigned W = $clog2(N);

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         nest = 1'b0;
    logic [N-1:0] irq = '0;
    logic         ack = 1'b0;
    logic         eos = 1'b0;
    logic         int_o, active;
    logic [W-1:0] svc;
    int           n_chk = 0;
    int           n_fail = 0;
    bit           done = 1'b0;

    always #2 clk = ~clk;

    prio_irq_ctrl #(.N_LINES(N)) i_prio_irq_ctrl (
        .clk(clk), .rst_n(rst_n), .nest_mode_i(nest), .irq_i(irq),
        .ack_i(ack), .eos_i(eos), .int_o(int_o), .active_o(active), .svc_id_o(svc)
    );

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic pulse(input logic [N-1:0] m);
        irq = irq | m;
        @(negedge clk);
        irq = irq & ~m;
    endtask

    task automatic do_ack();
        ack = 1'b1; @(negedge clk); ack = 1'b0;
    endtask

    task automatic do_eos();
        eos = 1'b1; @(negedge clk); eos = 1'b0;
    endtask

    task automatic t_reset();
        check("R1 int_o", int_o, 0);
        check("R1 active_o", active, 0);
        check("R1 svc_id_o", svc, 0);
    endtask

    task automatic t_ack_idle();
        do_ack();
        check("R10 active after idle ack", active, 0);
        check("R10 int after idle ack", int_o, 0);
    endtask

    task automatic t_queue_order();
        nest = 1'b0;
        pulse(8'h04);
        check("R2 pulse raises int", int_o, 1);
        do_ack();
        check("R2 svc line 2", svc, 2);
        check("R2 int clears after ack", int_o, 0);
        pulse(8'h02);
        pulse(8'h20);
        pulse(8'h48);
        check("R4 int quiet while busy", int_o, 0);
        do_eos();
        check("R4 waiting request offered", int_o, 1);
        do_ack(); check("R5 oldest first", svc, 1);
        do_eos(); do_ack(); check("R5 second oldest", svc, 5);
        do_eos(); do_ack(); check("R5 simultaneous higher first", svc, 6);
        do_eos(); do_ack(); check("R5 simultaneous lower next", svc, 3);
        do_eos();
        check("R8 queue empty", active, 0);
        check("R8 no int left", int_o, 0);
    endtask

    task automatic t_level();
        nest = 1'b0;
        irq[4] = 1'b1;
        @(negedge clk);
        check("R2 level raises int", int_o, 1);
        do_ack(); do_eos();
        check("R2 held level not re-pended", int_o, 0);
        irq[4] = 1'b0;
        @(negedge clk);
    endtask

    task automatic t_nest();
        nest = 1'b1;
        pulse(8'h04);
        do_ack();
        check("R6 svc line 2", svc, 2);
        pulse(8'h04);
        check("R7 equal level held off", int_o, 0);
        pulse(8'h02);
        check("R7 lower level held off", int_o, 0);
        pulse(8'h20);
        check("R6 higher raises int", int_o, 1);
        do_ack();
        check("R6 pre-empted to 5", svc, 5);
        do_eos();
        check("R8 back to 2", svc, 2);
        check("R7 still held off", int_o, 0);
        do_eos();
        check("R8 pending offered after return", int_o, 1);
        do_ack(); check("R3 higher of 2 and 1", svc, 2);
        do_eos(); do_ack(); check("R3 then line 1", svc, 1);
        do_eos();
        check("R8 nest empty", active, 0);
    endtask

    task automatic t_nest_prio();
        nest = 1'b1;
        pulse(8'h16);
        do_ack();
        check("R3 highest of 1,2,4", svc, 4);
        check("R7 lower pending held", int_o, 0);
        do_eos(); do_ack(); check("R3 next 2", svc, 2);
        do_eos(); do_ack(); check("R3 last 1", svc, 1);
        do_eos();
        check("R8 empty after chain", active, 0);
    endtask

    task automatic t_same_cycle();
        nest = 1'b1;
        pulse(8'h08);
        do_ack();
        check("R9 svc line 3", svc, 3);
        pulse(8'h40);
        check("R9 line 6 offered", int_o, 1);
        ack = 1'b1; eos = 1'b1;
        @(negedge clk);
        ack = 1'b0; eos = 1'b0;
        check("R9 svc line 6", svc, 6);
        check("R9 active", active, 1);
        do_eos();
        check("R9 line 3 retired together", active, 0);
        check("R9 no int", int_o, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_ack_idle();
        t_queue_order();
        t_level();
        t_nest();
        t_nest_prio();
        t_same_cycle();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        #800000;
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule